// File: doc/BRIEF.md
# SPI Master Slave-Select Frame Controller

This block drives the active-low slave-select line of an SPI master and decides when the external shifter may start a word. A frame opens when the frame-active control bit is set and a transmit word is offered. Select then falls, and a programmable leading delay runs before the first word starts. Later words in the same frame follow without a leading delay. The frame closes either because the word that was sent carried an end-of-frame mark or because software cleared the frame-active bit. Select then stays low for a trailing delay and afterwards stays high for at least a next-frame delay before another frame may open.

Clearing the frame-active bit takes effect in the bit at once, but it never cuts a running word short: the controller waits for the shifter's done indication before it starts the trailing delay. If the clear lands while the leading delay is still running, no word is started at all and the frame closes through the trailing and next-frame delays. All delays are given in shift-clock units of `CLK_DIV` system cycles. A delay of N units occupies N*CLK_DIV+1 clock cycles, where the extra cycle is the state-entry cycle. A sticky transmit-shift-complete flag records finished words.

Top module: `ss_frame_ctrl`

## Requirements
- R1: After reset, ss_n_o is 1, shift_start_o is 0, frame_active_o is 0 and tsc_o is 0.
- R2: A pulse on frame_set_i sets frame_active_o on the next cycle. A clear write (clr_we_i with bit 0 of clr_wdata_i at 1) clears it on the next cycle, and the clear wins over a set in the same cycle. A clear write with bit 0 at 0 leaves the bit unchanged.
- R3: Select falls only when the frame bit is set and tx_valid_i is high. With the bit clear, a pending word leaves ss_n_o high. Once a frame opens, ss_n_o is low for lead_units_i*CLK_DIV+1 cycles before the first shift_start_o cycle.
- R4: shift_start_o is a one-cycle pulse with ss_n_o low. In that cycle shift_data_o holds the word that tx_data_i carried when the start was issued.
- R5: Within a frame, the next word starts without a leading delay once the previous one is done, and ss_n_o stays low between words.
- R6: A word sent with tx_eof_i at 1 ends the frame. After the cycle in which shift_done_i completes that word, ss_n_o stays low for exactly trail_units_i*CLK_DIV+1 cycles.
- R7: A clear write during a running word drops frame_active_o on the next cycle while ss_n_o stays low. After that word's done, the trailing delay of R6 applies.
- R8: A clear write during the leading delay starts no word. Counting from the cycle after the write, ss_n_o stays low for trail_units_i*CLK_DIV+2 cycles.
- R9: After select rises, it stays high for gap_units_i*CLK_DIV+1 cycles plus one idle cycle, so for at least gap_units_i*CLK_DIV+2 cycles, before a new frame can pull it low.
- R10: tsc_o is set in the cycle after a word's done and stays set until a clear write with bit 1 of clr_wdata_i at 1. That write leaves frame_active_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tx_valid_i | input | 1 | A transmit word is offered |
| tx_data_i | input | DATA_W | Offered transmit word |
| tx_eof_i | input | 1 | Offered word closes the frame |
| frame_set_i | input | 1 | Strobe that sets the frame-active bit |
| clr_we_i | input | 1 | Write strobe of the write-1-to-clear word |
| clr_wdata_i | input | CLR_W | Clear word: bit 0 frame-active, bit 1 shift-complete flag |
| lead_units_i | input | DLY_W | Leading delay in shift-clock units |
| trail_units_i | input | DLY_W | Trailing delay in shift-clock units |
| gap_units_i | input | DLY_W | Next-frame delay in shift-clock units |
| shift_done_i | input | 1 | Shifter has finished the current word |
| ss_n_o | output | 1 | Active-low slave select |
| shift_start_o | output | 1 | One-cycle request to start a word |
| shift_data_o | output | DATA_W | Word handed to the shifter |
| frame_active_o | output | 1 | Frame-active control bit |
| tsc_o | output | 1 | Sticky transmit-shift-complete flag |

## Verification
The bench builds the block with CLK_DIV=3 and DLY_W=4. One unit therefore spans several clock cycles, so a count that is off by one unit or by one cycle gives a different measured length. Delays are drawn from 0 to 4 units, which covers zero-length leading, trailing and gap delays next to multi-unit ones. Frames of one to four words end by end-of-frame, by a clear during the last word, or by a clear during the leading delay, and shifter latencies vary from zero to four cycles.

// File: rtl/ssfc_pkg.sv
package ssfc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TRAIL,
    ST_NEXT
  } ssfc_state_e;
endpackage

// File: rtl/ssfc_delay.sv
module ssfc_delay #(
  parameter int DLY_W   = 4,
  parameter int CLK_DIV = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] units_i,
  output logic             zero_o
);
  localparam int CNT_W = DLY_W + $clog2(CLK_DIV) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] load_val;

  generate
    if (CLK_DIV == 1) begin : g_div1
      assign load_val = CNT_W'(units_i);
    end else begin : g_divn
      assign load_val = CNT_W'(units_i) * CNT_W'(CLK_DIV);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/ssfc_regs.sv
module ssfc_regs #(
  parameter int CLR_W   = 8,
  parameter int FA_BIT  = 0,
  parameter int TSC_BIT = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             clr_we_i,
  input  logic [CLR_W-1:0] clr_wdata_i,
  input  logic             word_done_i,
  output logic             frame_o,
  output logic             tsc_o
);
  logic clr_frame, clr_tsc;

  assign clr_frame = clr_we_i && clr_wdata_i[FA_BIT];
  assign clr_tsc   = clr_we_i && clr_wdata_i[TSC_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_o <= 1'b0;
      tsc_o   <= 1'b0;
    end else begin
      if (clr_frame)  frame_o <= 1'b0;
      else if (set_i) frame_o <= 1'b1;
      // hardware event beats software clear
      if (word_done_i)  tsc_o <= 1'b1;
      else if (clr_tsc) tsc_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ssfc_fsm.sv
module ssfc_fsm
  import ssfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DLY_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_eof_i,
  input  logic              shift_done_i,
  input  logic              zero_i,
  input  logic [DLY_W-1:0]  lead_units_i,
  input  logic [DLY_W-1:0]  trail_units_i,
  input  logic [DLY_W-1:0]  gap_units_i,
  output logic              load_o,
  output logic [DLY_W-1:0]  units_o,
  output logic              word_done_o,
  output logic              ss_n_o,
  output logic              shift_start_o,
  output logic [DATA_W-1:0] shift_data_o
);
  ssfc_state_e st_q, st_d;
  logic busy_q, eof_q, issue;

  assign word_done_o = (st_q == ST_SHIFT) && busy_q && shift_done_i;

  always_comb begin
    st_d    = st_q;
    load_o  = 1'b0;
    units_o = lead_units_i;
    issue   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (frame_i && tx_valid_i) begin
        st_d   = ST_LEAD;
        load_o = 1'b1;
      end
      ST_LEAD: begin
        if (!frame_i) begin
          st_d    = ST_TRAIL;
          load_o  = 1'b1;
          units_o = trail_units_i;
        end else if (zero_i) begin
          st_d  = ST_SHIFT;
          issue = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (busy_q) begin
          if (shift_done_i && (eof_q || !frame_i)) begin
            st_d    = ST_TRAIL;
            load_o  = 1'b1;
            units_o = trail_units_i;
          end
        end else if (!frame_i) begin
          st_d    = ST_TRAIL;
          load_o  = 1'b1;
          units_o = trail_units_i;
        end else if (tx_valid_i) begin
          issue = 1'b1;
        end
      end
      ST_TRAIL: if (zero_i) begin
        st_d    = ST_NEXT;
        load_o  = 1'b1;
        units_o = gap_units_i;
      end
      ST_NEXT: if (zero_i) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q          <= ST_IDLE;
      busy_q        <= 1'b0;
      eof_q         <= 1'b0;
      shift_start_o <= 1'b0;
      shift_data_o  <= '0;
    end else begin
      st_q          <= st_d;
      shift_start_o <= issue;
      if (issue) begin
        busy_q       <= 1'b1;
        eof_q        <= tx_eof_i;
        shift_data_o <= tx_data_i;
      end else if (word_done_o) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign ss_n_o = !(st_q inside {ST_LEAD, ST_SHIFT, ST_TRAIL});
endmodule

// File: rtl/ss_frame_ctrl.sv
module ss_frame_ctrl #(
  parameter int DATA_W  = 8,
  parameter int DLY_W   = 4,
  parameter int CLK_DIV = 2,
  parameter int CLR_W   = 8,
  parameter int FA_BIT  = 0,
  parameter int TSC_BIT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_eof_i,
  input  logic              frame_set_i,
  input  logic              clr_we_i,
  input  logic [CLR_W-1:0]  clr_wdata_i,
  input  logic [DLY_W-1:0]  lead_units_i,
  input  logic [DLY_W-1:0]  trail_units_i,
  input  logic [DLY_W-1:0]  gap_units_i,
  input  logic              shift_done_i,
  output logic              ss_n_o,
  output logic              shift_start_o,
  output logic [DATA_W-1:0] shift_data_o,
  output logic              frame_active_o,
  output logic              tsc_o
);
  logic dly_load, dly_zero, word_done;
  logic [DLY_W-1:0] dly_units;

  ssfc_regs #(.CLR_W(CLR_W), .FA_BIT(FA_BIT), .TSC_BIT(TSC_BIT)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (frame_set_i),
    .clr_we_i    (clr_we_i),
    .clr_wdata_i (clr_wdata_i),
    .word_done_i (word_done),
    .frame_o     (frame_active_o),
    .tsc_o       (tsc_o)
  );

  ssfc_delay #(.DLY_W(DLY_W), .CLK_DIV(CLK_DIV)) u_delay (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (dly_load),
    .units_i (dly_units),
    .zero_o  (dly_zero)
  );

  ssfc_fsm #(.DATA_W(DATA_W), .DLY_W(DLY_W)) u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .frame_i       (frame_active_o),
    .tx_valid_i    (tx_valid_i),
    .tx_data_i     (tx_data_i),
    .tx_eof_i      (tx_eof_i),
    .shift_done_i  (shift_done_i),
    .zero_i        (dly_zero),
    .lead_units_i  (lead_units_i),
    .trail_units_i (trail_units_i),
    .gap_units_i   (gap_units_i),
    .load_o        (dly_load),
    .units_o       (dly_units),
    .word_done_o   (word_done),
    .ss_n_o        (ss_n_o),
    .shift_start_o (shift_start_o),
    .shift_data_o  (shift_data_o)
  );
endmodule

// File: rtl/ssfc_checker.sv
module ssfc_checker #(
  parameter int CLR_W  = 8,
  parameter int FA_BIT = 0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ss_n_o,
  input logic             shift_start_o,
  input logic             shift_done_i,
  input logic             frame_active_o,
  input logic             tsc_o,
  input logic             clr_we_i,
  input logic [CLR_W-1:0] clr_wdata_i
);
  a_r2_clear_takes_effect: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_we_i && clr_wdata_i[FA_BIT]) |=> !frame_active_o);

  a_r4_start_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_start_o |=> !shift_start_o);

  a_r4_start_under_select: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_start_o |-> !ss_n_o);

  a_r3_start_needs_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_start_o |-> $past(frame_active_o));

  a_r9_gap_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ss_n_o) |=> ss_n_o);

  a_r10_flag_from_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tsc_o) |-> $past(shift_done_i));
endmodule

bind ss_frame_ctrl ssfc_checker #(.CLR_W(CLR_W), .FA_BIT(FA_BIT)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ss_n_o         (ss_n_o),
  .shift_start_o  (shift_start_o),
  .shift_done_i   (shift_done_i),
  .frame_active_o (frame_active_o),
  .tsc_o          (tsc_o),
  .clr_we_i       (clr_we_i),
  .clr_wdata_i    (clr_wdata_i)
);

// File: tb/sim_ss_frame_ctrl.sv
module sim_ss_frame_ctrl;
  localparam int DATA_W  = 8;
  localparam int DLY_W   = 4;
  localparam int CLK_DIV = 3;
  localparam int CLR_W   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_valid = 1'b0, tx_eof = 1'b0, frame_set = 1'b0, clr_we = 1'b0, shift_done = 1'b0;
  logic [DATA_W-1:0] tx_data = '0;
  logic [CLR_W-1:0]  clr_wdata = '0;
  logic [DLY_W-1:0]  lead_u = '0, trail_u = '0, gap_u = '0;
  logic ss_n, shift_start, frame_active, tsc;
  logic [DATA_W-1:0] shift_data;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  ss_frame_ctrl #(.DATA_W(DATA_W), .DLY_W(DLY_W), .CLK_DIV(CLK_DIV), .CLR_W(CLR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tx_valid_i(tx_valid), .tx_data_i(tx_data),
    .tx_eof_i(tx_eof), .frame_set_i(frame_set), .clr_we_i(clr_we), .clr_wdata_i(clr_wdata),
    .lead_units_i(lead_u), .trail_units_i(trail_u), .gap_units_i(gap_u),
    .shift_done_i(shift_done), .ss_n_o(ss_n), .shift_start_o(shift_start),
    .shift_data_o(shift_data), .frame_active_o(frame_active), .tsc_o(tsc)
  );

  function automatic int lead_exp(int u);  return u * CLK_DIV + 1; endfunction
  function automatic int trail_exp(int u); return u * CLK_DIV + 1; endfunction
  function automatic int gap_exp(int u);   return u * CLK_DIV + 2; endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic nstep();
    @(negedge clk);
  endtask

  // mode 0: end by eof, 1: clear during last word, 2: clear during lead
  task automatic run_frame(input int k, input int mode, input int l, input int t,
                           input int n, input int prev_n, input bit first);
    int hi, lo, w, starts;
    logic [DATA_W-1:0] d;
    lead_u = DLY_W'(l); trail_u = DLY_W'(t); gap_u = DLY_W'(n);
    frame_set = 1'b1;
    d = DATA_W'($urandom);
    tx_data = d; tx_valid = 1'b1; tx_eof = (mode == 0 && k == 1);
    hi = 0;
    while (ss_n) begin hi++; nstep(); frame_set = 1'b0; end
    frame_set = 1'b0;
    if (!first) chk(hi == gap_exp(prev_n), "R9 gap", hi, gap_exp(prev_n));
    if (mode == 2) begin
      nstep();
      clr_we = 1'b1; clr_wdata = 8'h01;
      nstep();
      clr_we = 1'b0; clr_wdata = '0;
      chk(frame_active == 1'b0, "R2 clear in lead", int'(frame_active), 0);
      lo = 0; starts = 0;
      while (!ss_n) begin
        if (shift_start) starts++;
        lo++; nstep();
      end
      chk(starts == 0, "R8 no word", starts, 0);
      chk(lo == t * CLK_DIV + 2, "R8 release", lo, t * CLK_DIV + 2);
      tx_valid = 1'b0;
      return;
    end
    lo = 0;
    while (!shift_start) begin lo++; nstep(); end
    chk(lo == lead_exp(l), "R3 lead", lo, lead_exp(l));
    for (int i = 0; i < k; i++) begin
      chk(shift_data == d, "R4 data", int'(shift_data), int'(d));
      chk(ss_n == 1'b0, "R4 select", int'(ss_n), 0);
      if (i + 1 < k) begin
        d = DATA_W'($urandom);
        tx_data = d; tx_eof = (mode == 0 && i + 2 == k);
      end else begin
        tx_valid = 1'b0; tx_eof = 1'b0;
      end
      nstep();
      chk(shift_start == 1'b0, "R4 pulse", int'(shift_start), 0);
      if (mode == 1 && i == k - 1) begin
        clr_we = 1'b1; clr_wdata = 8'h01;
        nstep();
        clr_we = 1'b0; clr_wdata = '0;
        chk(frame_active == 1'b0, "R7 bit drops", int'(frame_active), 0);
        chk(ss_n == 1'b0, "R7 select held", int'(ss_n), 0);
      end
      w = $urandom_range(0, 4);
      repeat (w) nstep();
      chk(ss_n == 1'b0, "R7 held while shifting", int'(ss_n), 0);
      shift_done = 1'b1;
      nstep();
      shift_done = 1'b0;
      chk(tsc == 1'b1, "R10 flag set", int'(tsc), 1);
      if (i < k - 1) begin
        while (!shift_start) begin
          chk(ss_n == 1'b0, "R5 select between words", int'(ss_n), 0);
          nstep();
        end
      end
    end
    lo = 0;
    while (!ss_n) begin lo++; nstep(); end
    if (mode == 0) chk(lo == trail_exp(t), "R6 trail", lo, trail_exp(t));
    else           chk(lo == trail_exp(t), "R7 trail", lo, trail_exp(t));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int prev_n, l, t, n, k, mode;
    bit fa;
    void'($urandom(32'd4711));
    nstep();
    chk(ss_n == 1'b1, "R1 ss_n", int'(ss_n), 1);
    chk(shift_start == 1'b0, "R1 start", int'(shift_start), 0);
    chk(frame_active == 1'b0, "R1 frame", int'(frame_active), 0);
    chk(tsc == 1'b0, "R1 tsc", int'(tsc), 0);
    nstep(); rst_n = 1'b1; nstep();

    // R2 directed
    frame_set = 1'b1; nstep(); frame_set = 1'b0;
    chk(frame_active == 1'b1, "R2 set", int'(frame_active), 1);
    clr_we = 1'b1; clr_wdata = 8'hFE; nstep(); clr_we = 1'b0;
    chk(frame_active == 1'b1, "R2 bit0 zero ignored", int'(frame_active), 1);
    clr_we = 1'b1; clr_wdata = 8'h01; frame_set = 1'b1; nstep();
    clr_we = 1'b0; frame_set = 1'b0; clr_wdata = '0;
    chk(frame_active == 1'b0, "R2 clear wins", int'(frame_active), 0);

    // R3: word pending without frame bit
    tx_valid = 1'b1; tx_data = 8'h5A;
    for (int i = 0; i < 8; i++) begin
      nstep();
      chk(ss_n == 1'b1 && shift_start == 1'b0, "R3 no frame no select", int'(ss_n), 1);
    end
    tx_valid = 1'b0;
    nstep();

    // directed: zero delays, then random frames
    run_frame(2, 0, 0, 0, 0, 0, 1'b1);
    prev_n = 0;
    run_frame(1, 1, 2, 1, 3, prev_n, 1'b0); prev_n = 3;
    run_frame(1, 2, 1, 2, 1, prev_n, 1'b0); prev_n = 1;
    for (int f = 0; f < 14; f++) begin
      mode = $urandom_range(0, 2);
      k = $urandom_range(1, 4);
      l = (mode == 2) ? $urandom_range(1, 4) : $urandom_range(0, 4);
      t = $urandom_range(0, 4);
      n = $urandom_range(0, 4);
      run_frame(k, mode, l, t, n, prev_n, 1'b0);
      prev_n = n;
    end

    // R10 flag clear leaves frame bit alone
    repeat (20) nstep();
    fa = frame_active;
    clr_we = 1'b1; clr_wdata = 8'h02; nstep(); clr_we = 1'b0; clr_wdata = '0;
    chk(tsc == 1'b0, "R10 flag clear", int'(tsc), 0);
    chk(frame_active == fa, "R10 frame unchanged", int'(frame_active), int'(fa));

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule